// File: doc/BRIEF.md
# Master Clock Source Selector

This block chooses the master clock for two output clock groups, R and S. There are three candidate clocks: a recovered PLL clock, a crystal or external XIN clock, and an external TMCK clock. A primary source is either the PLL clock or TMCK, picked by a source bit. While the primary source is healthy, each group follows it. When the PLL is locked, or TMCK is present and synchronised, the primary is healthy. When the primary is not healthy, the group drops back to XIN on its own. A per-group force bit sends the group to XIN whatever the lock state.

A split-mode bit sets how the two groups are steered. When split mode is clear, both groups follow one shared force bit. When split mode is set, R follows its own force bit and S stays on XIN. Each group has its own glitch-free clock multiplexer. The multiplexer turns off the old clock on that clock's falling edge. It waits until every other domain has seen that disable, and then turns on the new clock on the new clock's falling edge. Lock and sync inputs are brought into each clock domain through two-flop synchronisers.

The block has two more outputs. An XIN monitor output gives XIN undivided, XIN divided by two, or a constant low level. An error flag shows the true health of the primary source, even when XIN is forced.

Top module: `mclk_source_sel`

## Requirements
- R1: With `split_mode`=0, both groups run from XIN when `grp_xin_force`=1. When `grp_xin_force`=0, both groups run from the primary source if it is healthy, and from XIN if it is not.
- R2: With `split_mode`=1, the S group always runs from XIN. The R group follows the R1 rule, but uses `r_xin_force` in place of `grp_xin_force`.
- R3: With `use_tmck`=0, the primary source is the PLL clock and it is healthy when `pll_lock`=1. With `use_tmck`=1, the primary source is TMCK and it is healthy when `tmck_sync_ok`=1.
- R4: In each group's multiplexer, at most one source enable is high at any time. Each enable changes only on the falling edge of its own clock.
- R5: Neither `r_mclk` nor `s_mclk` ever produces a high or low pulse shorter than half the period of the fastest source. This holds across automatic switches and across commanded switches.
- R6: `lock_err` is 1 when the primary source is unhealthy and 0 when it is healthy. This holds whatever the force bits are set to. The flag reaches the output through two XIN-clocked flops.
- R7: `mon_sel` sets the monitor output. 2'b00 gives XIN undivided, 2'b01 gives XIN divided by two, and 2'b10 or 2'b11 holds `xin_mon` low.
- R8: While `rst_n` is low, `r_mclk`, `s_mclk` and `xin_mon` are low and `lock_err` is 1.
- R9: Just after reset is released, each group output stays low until its enable has passed through synchronisation. The output then comes up on the source that R1 to R3 select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pll | input | 1 | Recovered PLL clock |
| clk_xin | input | 1 | Crystal or external XIN clock |
| clk_tmck | input | 1 | External TMCK clock |
| pll_lock | input | 1 | PLL lock indicator, asynchronous |
| tmck_sync_ok | input | 1 | TMCK present and data synchronised, asynchronous |
| use_tmck | input | 1 | Sets TMCK as the primary source in place of the PLL clock |
| split_mode | input | 1 | 1: R follows r_xin_force and S is held on XIN |
| grp_xin_force | input | 1 | Shared force-to-XIN bit, used when split_mode=0 |
| r_xin_force | input | 1 | R-group force-to-XIN bit, used when split_mode=1 |
| mon_sel | input | 2 | Monitor mode: 00 undivided, 01 divided by two, 1x muted |
| r_mclk | output | 1 | R group master clock |
| s_mclk | output | 1 | S group master clock |
| xin_mon | output | 1 | XIN monitor output |
| lock_err | output | 1 | Primary source unhealthy flag |

## Verification
The bench moves the block through every mode, force and lock combination. Each move comes straight after the previous one, so every switch starts from a different source. The bench identifies which clock reached each group by measuring the high-pulse width, since each source has a distinct width. A group that fell back to XIN in the wrong mode, or took the PLL clock when TMCK was the primary, would show the wrong width. A multiplexer that enables the new clock before the old one is off would produce a pulse shorter than half the fastest period. A monitor on every edge of both group outputs catches such a runt. The bench also forces XIN while the primary is unhealthy, to confirm that the error flag does not follow the force bits. It checks the output right after reset release, where an enable that skipped synchronisation would let a clock through too early.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_XIN  = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_TMCK = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    MON_DIV1 = 2'd0,
    MON_DIV2 = 2'd1,
    MON_MUTE = 2'd2
  } mon_e;

  // Primary health: PLL lock or TMCK sync, chosen by the source bit.
  function automatic logic primary_good(input logic use_tmck, input logic pll_lock,
                                        input logic tmck_ok);
    return use_tmck ? tmck_ok : pll_lock;
  endfunction

  // Source for one group from its force bit and primary health.
  function automatic src_e pick_src(input logic force_xin, input logic good,
                                    input logic use_tmck);
    if (force_xin || !good) return SRC_XIN;
    return use_tmck ? SRC_TMCK : SRC_PLL;
  endfunction

  function automatic logic [NSRC-1:0] src_onehot(input src_e s);
    return NSRC'(1) << s;
  endfunction

  function automatic mon_e mon_decode(input logic [1:0] code);
    case (code)
      2'b00:   return MON_DIV1;
      2'b01:   return MON_DIV2;
      default: return MON_MUTE;
    endcase
  endfunction

endpackage

// File: rtl/csel_sync.sv
module csel_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/csel_gfmux.sv
module csel_gfmux #(
  parameter int NSRC        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            rst_n,
  input  logic [NSRC-1:0] clk_src,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] src_on,
  output logic            clk_out
);

  logic [NSRC-1:0] en_q;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    logic busy_async;
    logic req_s;
    logic busy_s;
    logic gate_q;
    logic en_bit;

    // Another source still enabled: this one must wait.
    assign busy_async = |(en_q & ~(NSRC'(1) << gi));

    csel_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_req_sync (
      .clk(clk_src[gi]), .rst_n(rst_n), .d(req[gi]), .q(req_s));

    csel_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_busy_sync (
      .clk(clk_src[gi]), .rst_n(rst_n), .d(busy_async), .q(busy_s));

    always_ff @(posedge clk_src[gi] or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= req_s & ~busy_s;
    end

    // Enable moves only while this clock is low.
    always_ff @(negedge clk_src[gi] or negedge rst_n) begin
      if (!rst_n) en_bit <= 1'b0;
      else        en_bit <= gate_q;
    end

    assign en_q[gi] = en_bit;

    // R4: enable seen at a rising edge equals the value latched at the prior fall
    a_r4_enable_on_fall: assert property (@(posedge clk_src[gi]) disable iff (!rst_n)
      en_bit == gate_q)
      else $error("enable changed outside falling edge, source %0d", gi);
  end

  assign src_on  = en_q;
  assign clk_out = |(clk_src & en_q);

  // R4: never two sources gated onto the output at once
  always_comb begin
    a_r4_single_enable: assert ($onehot0(en_q))
      else $error("more than one source enabled: %b", en_q);
  end

endmodule

// File: rtl/csel_xmon.sv
module csel_xmon
  import csel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_xin,
  input  logic       rst_n,
  input  logic [1:0] mon_sel,
  output logic       xin_mon
);

  logic [1:0] sel_s;
  mon_e       mode_q;
  logic       div_q;

  csel_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b10)) u_sel_sync (
    .clk(clk_xin), .rst_n(rst_n), .d(mon_sel), .q(sel_s));

  // Mode applied while XIN is low.
  always_ff @(negedge clk_xin or negedge rst_n) begin
    if (!rst_n) mode_q <= MON_MUTE;
    else        mode_q <= mon_decode(sel_s);
  end

  always_ff @(posedge clk_xin or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= ~div_q;
  end

  always_comb begin
    case (mode_q)
      MON_DIV1: xin_mon = clk_xin;
      MON_DIV2: xin_mon = div_q;
      default:  xin_mon = 1'b0;
    endcase
  end

  // R7: muted mode keeps the monitor low
  a_r7_mute_low: assert property (@(posedge clk_xin) disable iff (!rst_n)
    (mode_q == MON_MUTE) |-> !xin_mon)
    else $error("monitor output active while muted");

endmodule

// File: rtl/mclk_source_sel.sv
module mclk_source_sel
  import csel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE      = 24
) (
  input  logic       rst_n,
  input  logic       clk_pll,
  input  logic       clk_xin,
  input  logic       clk_tmck,
  input  logic       pll_lock,
  input  logic       tmck_sync_ok,
  input  logic       use_tmck,
  input  logic       split_mode,
  input  logic       grp_xin_force,
  input  logic       r_xin_force,
  input  logic [1:0] mon_sel,
  output logic       r_mclk,
  output logic       s_mclk,
  output logic       xin_mon,
  output logic       lock_err
);

  localparam int AGE_W = $clog2(SETTLE + 2);

  logic [NSRC-1:0] clk_vec;
  logic            good;
  logic            r_force;
  logic            s_force;
  src_e            r_src;
  src_e            s_src;
  logic [NSRC-1:0] r_req;
  logic [NSRC-1:0] s_req;
  logic [NSRC-1:0] r_on;
  logic [NSRC-1:0] s_on;

  assign clk_vec = {clk_tmck, clk_pll, clk_xin};

  assign good    = primary_good(use_tmck, pll_lock, tmck_sync_ok);
  assign r_force = split_mode ? r_xin_force : grp_xin_force;
  assign s_force = split_mode | grp_xin_force;
  assign r_src   = pick_src(r_force, good, use_tmck);
  assign s_src   = pick_src(s_force, good, use_tmck);
  assign r_req   = src_onehot(r_src);
  assign s_req   = src_onehot(s_src);

  csel_gfmux #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_r_mux (
    .rst_n(rst_n), .clk_src(clk_vec), .req(r_req), .src_on(r_on), .clk_out(r_mclk));

  csel_gfmux #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_s_mux (
    .rst_n(rst_n), .clk_src(clk_vec), .req(s_req), .src_on(s_on), .clk_out(s_mclk));

  csel_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_err_sync (
    .clk(clk_xin), .rst_n(rst_n), .d(~good), .q(lock_err));

  csel_xmon #(.SYNC_STAGES(SYNC_STAGES)) u_xmon (
    .clk_xin(clk_xin), .rst_n(rst_n), .mon_sel(mon_sel), .xin_mon(xin_mon));

  // Hold-time counters in the XIN domain for the checks below.
  logic [AGE_W-1:0] split_age;
  logic [AGE_W-1:0] bad_age;

  always_ff @(posedge clk_xin or negedge rst_n) begin
    if (!rst_n) begin
      split_age <= '0;
      bad_age   <= '0;
    end else begin
      if (!split_mode)                 split_age <= '0;
      else if (split_age <= AGE_W'(SETTLE)) split_age <= split_age + 1'b1;
      if (good)                        bad_age <= '0;
      else if (bad_age <= AGE_W'(SETTLE))   bad_age <= bad_age + 1'b1;
    end
  end

  // R2: split mode held long enough leaves only XIN enabled in the S group
  a_r2_split_s_xin: assert property (@(posedge clk_xin) disable iff (!rst_n)
    (split_age > AGE_W'(SETTLE)) |-> (s_on == NSRC'(1)))
    else $error("S group not on XIN in split mode: %b", s_on);

  // R6: unhealthy primary held for a few XIN cycles raises the flag
  a_r6_err_on_bad: assert property (@(posedge clk_xin) disable iff (!rst_n)
    (bad_age > AGE_W'(3)) |-> lock_err)
    else $error("error flag low while primary unhealthy");

endmodule

// File: tb/test_mclk_source_sel.sv
`timescale 1ns/1ps
module test_mclk_source_sel;

  // XIN 125 MHz (8 ns), PLL 10 ns, TMCK 14 ns: high widths 4, 5, 7 ns.
  localparam real HALF_XIN  = 4.0;
  localparam real HALF_PLL  = 5.0;
  localparam real HALF_TMCK = 7.0;
  localparam real MIN_PULSE = HALF_XIN - 0.01;
  localparam int  NV = 14;

  // {use_tmck, split, grp_force, r_force, pll_lock, tmck_ok, exp_r[1:0], exp_s[1:0], exp_err}
  // source codes: 0 XIN, 1 PLL, 2 TMCK
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_0_0_1_0_01_01_0,
    11'b0_0_0_0_0_0_00_00_1,
    11'b0_0_1_0_1_0_00_00_0,
    11'b0_1_0_0_1_0_01_00_0,
    11'b0_1_0_1_1_0_00_00_0,
    11'b0_1_1_0_1_0_01_00_0,
    11'b1_0_0_0_0_1_10_10_0,
    11'b1_0_0_0_1_0_00_00_1,
    11'b1_1_0_0_0_1_10_00_0,
    11'b1_1_0_1_0_1_00_00_0,
    11'b0_0_0_0_1_1_01_01_0,
    11'b1_0_1_0_0_1_00_00_0,
    11'b0_1_1_1_0_0_00_00_1,
    11'b0_0_0_0_1_0_01_01_0
  };

  logic rst_n = 1'b0;
  logic clk_pll = 1'b0, clk_xin = 1'b0, clk_tmck = 1'b0;
  logic pll_lock = 1'b1, tmck_sync_ok = 1'b0, use_tmck = 1'b0;
  logic split_mode = 1'b0, grp_xin_force = 1'b0, r_xin_force = 1'b0;
  logic [1:0] mon_sel = 2'b00;
  logic r_mclk, s_mclk, xin_mon, lock_err;

  int total = 0;
  int bad   = 0;
  int runts = 0;
  int mon_edges = 0;
  realtime last_r = -1.0, last_s = -1.0;

  always #4 clk_xin  = ~clk_xin;
  always #5 clk_pll  = ~clk_pll;
  always #7 clk_tmck = ~clk_tmck;

  mclk_source_sel i_mclk_source_sel (
    .rst_n(rst_n), .clk_pll(clk_pll), .clk_xin(clk_xin), .clk_tmck(clk_tmck),
    .pll_lock(pll_lock), .tmck_sync_ok(tmck_sync_ok), .use_tmck(use_tmck),
    .split_mode(split_mode), .grp_xin_force(grp_xin_force), .r_xin_force(r_xin_force),
    .mon_sel(mon_sel), .r_mclk(r_mclk), .s_mclk(s_mclk), .xin_mon(xin_mon),
    .lock_err(lock_err));

  // R5: every pulse on both group outputs is timed.
  always @(r_mclk) if (rst_n) begin
    if (last_r >= 0.0 && ($realtime - last_r) < MIN_PULSE) begin
      runts++;
      $display("FAIL R5 r_mclk pulse actual=%0.3f expected>=%0.3f", $realtime - last_r, MIN_PULSE);
    end
    last_r = $realtime;
  end

  always @(s_mclk) if (rst_n) begin
    if (last_s >= 0.0 && ($realtime - last_s) < MIN_PULSE) begin
      runts++;
      $display("FAIL R5 s_mclk pulse actual=%0.3f expected>=%0.3f", $realtime - last_s, MIN_PULSE);
    end
    last_s = $realtime;
  end

  always @(xin_mon) mon_edges++;

  function automatic real width_of(input logic [1:0] code);
    case (code)
      2'd1:    return HALF_PLL;
      2'd2:    return HALF_TMCK;
      default: return HALF_XIN;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic hi_width(input int which, output real w);
    realtime t0;
    case (which)
      0: begin @(posedge r_mclk);  t0 = $realtime; @(negedge r_mclk);  end
      1: begin @(posedge s_mclk);  t0 = $realtime; @(negedge s_mclk);  end
      default: begin @(posedge xin_mon); t0 = $realtime; @(negedge xin_mon); end
    endcase
    w = $realtime - t0;
  endtask

  function automatic bit near(input real a, input real b);
    return (a > b - 0.01) && (a < b + 0.01);
  endfunction

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    real w;
    logic [10:0] v;
    int e0;

    // R8: reset state
    #51;
    check(!r_mclk && !s_mclk && !xin_mon, "R8", "outputs low in reset",
          real'({r_mclk, s_mclk, xin_mon}), 0.0);
    check(lock_err == 1'b1, "R8", "error flag high in reset", real'(lock_err), 1.0);

    // R9: outputs still low right after release
    #49 rst_n = 1'b1;
    #1;
    check(!r_mclk && !s_mclk, "R9", "outputs low just after release",
          real'({r_mclk, s_mclk}), 0.0);
    #500;
    hi_width(0, w);
    check(near(w, HALF_PLL), "R9", "r_mclk comes up on PLL", w, HALF_PLL);

    // R1 R2 R3 R6: table walk, each vector switching from the previous one
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      #0.3;
      {use_tmck, split_mode, grp_xin_force, r_xin_force, pll_lock, tmck_sync_ok} = v[10:5];
      #600;
      hi_width(0, w);
      check(near(w, width_of(v[4:3])), v[9] ? "R2" : (v[10] ? "R3" : "R1"),
            $sformatf("vec %0d r_mclk width", k), w, width_of(v[4:3]));
      hi_width(1, w);
      check(near(w, width_of(v[2:1])), v[9] ? "R2" : "R1",
            $sformatf("vec %0d s_mclk width", k), w, width_of(v[2:1]));
      #1.5;
      check(lock_err == v[0], "R6", $sformatf("vec %0d error flag", k),
            real'(lock_err), real'(v[0]));
    end

    // R7: monitor modes
    mon_sel = 2'b00;
    #200;
    hi_width(2, w);
    check(near(w, HALF_XIN), "R7", "monitor undivided", w, HALF_XIN);
    mon_sel = 2'b01;
    #200;
    hi_width(2, w);
    check(near(w, 2.0 * HALF_XIN), "R7", "monitor divided by two", w, 2.0 * HALF_XIN);
    mon_sel = 2'b10;
    #200;
    e0 = mon_edges;
    #200;
    check(mon_edges == e0 && !xin_mon, "R7", "monitor muted 10",
          real'(mon_edges - e0), 0.0);
    mon_sel = 2'b11;
    #200;
    e0 = mon_edges;
    #200;
    check(mon_edges == e0 && !xin_mon, "R7", "monitor muted 11",
          real'(mon_edges - e0), 0.0);

    // R5: summary of the pulse monitor across all switches
    check(runts == 0, "R5", "runt pulses seen", real'(runts), 0.0);

    // R8: reset again mid-run
    #3.3 rst_n = 1'b0;
    #1;
    check(!r_mclk && !s_mclk && !xin_mon && lock_err, "R8", "outputs after second reset",
          real'({r_mclk, s_mclk, xin_mon, lock_err}), 1.0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule